// File: doc/BRIEF.md
# Output Channel Divider with Half-Cycle Coarse Delay

This block is the divider for one clock output channel. It runs on a fast input clock and makes an output clock whose period is a programmable whole number of input periods. The start of that output can be pushed back by a programmable number of half input periods. The output's high and low phases are each exactly one half of its period, measured in half input periods. An odd ratio therefore gives a 50% duty output, because the block switches on falling input edges as well as rising ones. Every output transition falls on an input clock edge. Shifting the phase adds no new timing source.

The ratio and delay inputs may change at any time. The divider takes them only when a sync strobe is sampled. On that edge it also restarts its count, so channels synced by the same strobe start from a common point. After a sync the output stays low for the chosen number of half periods and then begins high. A phase-valid flag reports when the first full output period has finished. A source select routes an auxiliary signal, such as a frame-alignment pulse, to the output in place of the divided clock.

Top module: `chan_div`

## Requirements
- R1: After reset, and until the first sync, clk_out (with src_sel=0) and phase_valid are low.
- R2: With effective ratio N (a ratio input of 0 counts as 1), the divided output repeats every 2N half input periods.
- R3: In each period the output is high for exactly N half input periods and then low for N. An odd N changes level on falling input edges.
- R4: Take half period 0 as the high phase of the input clock that begins at the sync edge. After the sync the output is low for D half periods, where D is the delay input sampled at that edge, and goes high at the start of half period D.
- R5: A ratio of 0 or 1 with an even delay reproduces the input clock once the delay has passed.
- R6: Changing ratio_in or delay_in while sync_req is low has no effect on the output.
- R7: A sync while the divider is running drops the old phase at once. The new pattern starts at half period 0 of the sync edge.
- R8: phase_valid is low right after a sync edge. It goes high on the first rising input edge at or after half period D+2N and stays high until the next sync or reset.
- R9: With src_sel=1 the output follows aux_in. With src_sel=0 it carries the divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Sync strobe: loads ratio and delay and restarts the count |
| ratio_in | input | 8 | Divide ratio (0 treated as 1) |
| delay_in | input | 6 | Coarse delay in half input periods |
| src_sel | input | 1 | 0 selects the divided clock, 1 selects aux_in |
| aux_in | input | 1 | Auxiliary signal routed out when selected |
| clk_out | output | 1 | Channel output |
| phase_valid | output | 1 | High once the first full period after a sync has finished |

## Verification
The hardest case to reach is the one where a period wraps or the start point falls in the falling-edge half of an input cycle. In that case an odd ratio or an odd delay decides the level on the low phase of the input clock. The bench sweeps every ratio from 0 to 9 against even and odd delays, including the largest delay, and adds the largest ratios. It samples both halves of each input cycle and compares them with a modulo formula. Each configuration begins with a sync while the previous one is still running, which exercises restart. One run changes the inputs mid-period without a sync to show that the shadowed values hold.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // Output source choice for a channel.
  typedef enum logic {
    SRC_DIVIDED = 1'b0,
    SRC_AUX     = 1'b1
  } cdiv_src_e;
endpackage

// File: rtl/cdiv_shadow.sv
// Holds ratio and delay; loads them only on a sync edge.
module cdiv_shadow #(
  parameter int RATIO_W = 8,
  parameter int DELAY_W = 6
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               sync_req,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [DELAY_W-1:0] delay_in,
  output logic [RATIO_W-1:0] ratio_sh,
  output logic [DELAY_W-1:0] delay_sh,
  output logic [RATIO_W-1:0] ratio_eff,
  output logic [DELAY_W-1:0] delay_eff
);
  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

  // A ratio of zero behaves as divide-by-one.
  function automatic logic [RATIO_W-1:0] nz_ratio(input logic [RATIO_W-1:0] r);
    return (r == '0) ? RATIO_ONE : r;
  endfunction

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ratio_sh <= RATIO_ONE;
      delay_sh <= '0;
    end else if (sync_req) begin
      ratio_sh <= nz_ratio(ratio_in);
      delay_sh <= delay_in;
    end
  end

  // Values used on the current edge: fresh inputs on a sync edge.
  always_comb begin
    ratio_eff = sync_req ? nz_ratio(ratio_in) : ratio_sh;
    delay_eff = sync_req ? delay_in : delay_sh;
  end
endmodule

// File: rtl/cdiv_seq.sv
// Rising-edge sequencer: works out the levels of both half periods
// of the coming input cycle and tracks the first completed period.
module cdiv_seq #(
  parameter int RATIO_W = 8,
  parameter int DELAY_W = 6
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               sync_req,
  input  logic [RATIO_W-1:0] ratio_eff,
  input  logic [DELAY_W-1:0] delay_eff,
  output logic               rise_lvl,
  output logic               fall_lvl_pre,
  output logic               seq_run,
  output logic               phase_valid
);
  localparam int POS_W = RATIO_W + 1;

  typedef struct packed {
    logic               run;
    logic [DELAY_W-1:0] wait_h;
    logic [POS_W-1:0]   pos;
    logic               done;
    logic               lvl;
  } hstate_t;

  // Advance by one half input period.
  function automatic hstate_t step_half(input hstate_t s, input logic [RATIO_W-1:0] n);
    hstate_t r;
    logic [POS_W-1:0] last_pos;
    last_pos = {n, 1'b0} - 1'b1;
    r = s;
    r.lvl = 1'b0;
    if (s.run) begin
      if (s.wait_h != '0) begin
        r.wait_h = s.wait_h - 1'b1;
      end else begin
        r.lvl = (s.pos < {1'b0, n});
        if (s.pos == last_pos) begin
          r.pos  = '0;
          r.done = 1'b1;
        end else begin
          r.pos = s.pos + 1'b1;
        end
      end
    end
    return r;
  endfunction

  hstate_t cur_q, start_s, half_a, half_b;

  always_comb begin
    start_s.run    = 1'b1;
    start_s.wait_h = delay_eff;
    start_s.pos    = '0;
    start_s.done   = 1'b0;
    start_s.lvl    = 1'b0;
    half_a = step_half(sync_req ? start_s : cur_q, ratio_eff);
    half_b = step_half(half_a, ratio_eff);
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= '0;
      rise_lvl    <= 1'b0;
      phase_valid <= 1'b0;
    end else begin
      cur_q       <= half_b;
      rise_lvl    <= half_a.lvl;
      phase_valid <= sync_req ? 1'b0 : (phase_valid | cur_q.done);
    end
  end

  assign fall_lvl_pre = cur_q.lvl;
  assign seq_run      = cur_q.run;
endmodule

// File: rtl/cdiv_edge_out.sv
// Retimes the second-half level onto the falling edge and steers
// the output between the two halves and the auxiliary source.
module cdiv_edge_out (
  input  logic clk_in,
  input  logic rst_n,
  input  logic rise_lvl,
  input  logic fall_lvl_pre,
  input  logic src_sel,
  input  logic aux_in,
  output logic clk_out
);
  import cdiv_pkg::*;

  logic fall_lvl_q;
  logic div_lvl;

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) fall_lvl_q <= 1'b0;
    else        fall_lvl_q <= fall_lvl_pre;
  end

  always_comb begin
    div_lvl = clk_in ? rise_lvl : fall_lvl_q;
    clk_out = (cdiv_src_e'(src_sel) == SRC_AUX) ? aux_in : div_lvl;
  end
endmodule

// File: rtl/chan_div.sv
module chan_div #(
  parameter int RATIO_W = 8,
  parameter int DELAY_W = 6
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               sync_req,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [DELAY_W-1:0] delay_in,
  input  logic               src_sel,
  input  logic               aux_in,
  output logic               clk_out,
  output logic               phase_valid
);
  logic [RATIO_W-1:0] ratio_sh, ratio_eff;
  logic [DELAY_W-1:0] delay_sh, delay_eff;
  logic               rise_lvl, fall_lvl_pre, seq_run;

  cdiv_shadow #(.RATIO_W(RATIO_W), .DELAY_W(DELAY_W)) shadow_i (
    .clk_in(clk_in), .rst_n(rst_n), .sync_req(sync_req),
    .ratio_in(ratio_in), .delay_in(delay_in),
    .ratio_sh(ratio_sh), .delay_sh(delay_sh),
    .ratio_eff(ratio_eff), .delay_eff(delay_eff)
  );

  cdiv_seq #(.RATIO_W(RATIO_W), .DELAY_W(DELAY_W)) seq_i (
    .clk_in(clk_in), .rst_n(rst_n), .sync_req(sync_req),
    .ratio_eff(ratio_eff), .delay_eff(delay_eff),
    .rise_lvl(rise_lvl), .fall_lvl_pre(fall_lvl_pre),
    .seq_run(seq_run), .phase_valid(phase_valid)
  );

  cdiv_edge_out out_i (
    .clk_in(clk_in), .rst_n(rst_n), .rise_lvl(rise_lvl),
    .fall_lvl_pre(fall_lvl_pre), .src_sel(src_sel),
    .aux_in(aux_in), .clk_out(clk_out)
  );
endmodule

// File: rtl/chan_div_chk.sv
module chan_div_chk #(
  parameter int RATIO_W = 8,
  parameter int DELAY_W = 6
) (
  input logic               clk_in,
  input logic               rst_n,
  input logic               sync_req,
  input logic [DELAY_W-1:0] delay_in,
  input logic [RATIO_W-1:0] ratio_sh,
  input logic [DELAY_W-1:0] delay_sh,
  input logic               seq_run,
  input logic               rise_lvl,
  input logic               phase_valid
);
  // R1
  idle_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !seq_run |-> !rise_lvl);
  // R4
  delay_start_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sync_req && delay_in != '0) |=> !rise_lvl);
  // R4
  zero_delay_high_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sync_req && delay_in == '0) |=> rise_lvl);
  // R6
  shadow_stable_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !sync_req |=> ($stable(ratio_sh) && $stable(delay_sh)));
  // R8
  valid_clear_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    sync_req |=> !phase_valid);
  // R8
  valid_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (phase_valid && !sync_req) |=> phase_valid);
endmodule

bind chan_div chan_div_chk #(.RATIO_W(RATIO_W), .DELAY_W(DELAY_W)) chk_i (
  .clk_in(clk_in), .rst_n(rst_n), .sync_req(sync_req), .delay_in(delay_in),
  .ratio_sh(ratio_sh), .delay_sh(delay_sh), .seq_run(seq_run),
  .rise_lvl(rise_lvl), .phase_valid(phase_valid)
);

// File: tb/chan_div_tb_top.sv
`timescale 1ns/1ps
module chan_div_tb_top;
  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_req = 1'b0;
  logic [7:0] ratio_in = '0;
  logic [5:0] delay_in = '0;
  logic       src_sel = 1'b0;
  logic       aux_in = 1'b0;
  logic       clk_out, phase_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit running = 0;

  always #2.5 clk_in = ~clk_in;

  chan_div dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .sync_req(sync_req),
    .ratio_in(ratio_in), .delay_in(delay_in), .src_sel(src_sel),
    .aux_in(aux_in), .clk_out(clk_out), .phase_valid(phase_valid)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected level in half period h after a sync with ratio r, delay d.
  function automatic logic exp_lvl(input int h, input int r, input int d);
    int n;
    n = (r == 0) ? 1 : r;
    if (h < d) return 1'b0;
    return (((h - d) % (2 * n)) < n);
  endfunction

  function automatic string lvl_tag(input int h, input int r, input int d, input int k, input bit resync);
    if (k == 0 && resync) return "R7";
    if (h < d) return "R4";
    if (r <= 1) return "R5";
    return "R2 R3";
  endfunction

  task automatic run_cfg(input int r, input int d, input bit disturb);
    int n, ncyc;
    bit resync;
    n = (r == 0) ? 1 : r;
    ncyc = (d + 4 * n) / 2 + 3;
    resync = running;
    @(negedge clk_in);
    ratio_in = 8'(r);
    delay_in = 6'(d);
    sync_req = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk_in);
      #1.25;
      chk(lvl_tag(2 * k, r, d, k, resync), clk_out, exp_lvl(2 * k, r, d));
      // R8: valid from the first rising edge at or after half D+2N
      chk("R8", phase_valid, (2 * k >= d + 2 * n));
      @(negedge clk_in);
      sync_req = 1'b0;
      if (disturb && k == 2) begin
        // R6: inputs change without a sync
        ratio_in = 8'(r + 3);
        delay_in = 6'(d ^ 5);
      end
      #1.25;
      chk(disturb ? "R6" : lvl_tag(2 * k + 1, r, d, k, resync), clk_out, exp_lvl(2 * k + 1, r, d));
    end
    running = 1;
  endtask

  initial begin
    int dl[6] = '{0, 1, 2, 3, 8, 63};
    // R1: reset state and idle before any sync
    #1;
    chk("R1", clk_out, 1'b0);
    chk("R1", phase_valid, 1'b0);
    @(negedge clk_in);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1.25;
      chk("R1", clk_out, 1'b0);
      chk("R1", phase_valid, 1'b0);
    end

    for (int r = 0; r <= 9; r++)
      foreach (dl[j]) run_cfg(r, dl[j], 1'b0);
    run_cfg(255, 5, 1'b0);
    run_cfg(254, 63, 1'b0);
    run_cfg(13, 1, 1'b0);
    run_cfg(5, 3, 1'b1);
    run_cfg(7, 2, 1'b1);

    // R9: auxiliary source routed out
    @(negedge clk_in);
    src_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_in);
      aux_in = i[0];
      #1.25;
      chk("R9", clk_out, i[0]);
      @(posedge clk_in); #1.25;
      chk("R9", clk_out, i[0]);
    end
    @(negedge clk_in);
    src_sel = 1'b0;
    running = 0;
    run_cfg(3, 1, 1'b0);

    // R1: mid-run reset returns to idle until a sync
    @(negedge clk_in);
    rst_n = 1'b0;
    #1;
    chk("R1", clk_out, 1'b0);
    chk("R1", phase_valid, 1'b0);
    @(negedge clk_in);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_in); #1.25;
      chk("R1", clk_out, 1'b0);
      @(negedge clk_in); #1.25;
      chk("R1", clk_out, 1'b0);
    end
    running = 0;
    run_cfg(2, 0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule